// File: doc/BRIEF.md
# Ultrasonic Ranging Sensor Emulator

This block takes the place of a single-echo ultrasonic distance transducer in front of a controller under test. The controller raises a trigger line as it would to fire a real sensor; the block answers on an echo line after a delay that matches the round trip of sound to an obstacle at a simulated distance. A simulation host keeps that distance current through a one-cycle write strobe, so the controller sees a moving scene with no acoustics.

The trigger is asynchronous to the block clock and is re-timed through two flip-flops. A rising edge of the re-timed trigger starts a measurement. At that instant the most recently written distance is turned into a delay: the distance times a cycles-per-unit constant, raised to a floor equal to the length of the emulated transmit burst (16 cycles of a 49.4 kHz tone). A down-counter then runs off that delay and the echo goes high when it expires. The echo holds until the controller drops the trigger, and the block is then ready for the next rising edge.

Top module: `usonic_echo_emu`

## Requirements
- R1: While rst_n is low and after its release, with trig_i low, echo_o is 0.
- R2: The delay D in clock cycles is the stored distance times CYC_PER_UNIT. echo_o goes high exactly D+2 rising clock edges after the first rising edge at which trig_i is sampled high (2 edges for the two-flop synchroniser).
- R3: When the distance times CYC_PER_UNIT is below MIN_DLY_CYC, D equals MIN_DLY_CYC. This includes a distance of 0.
- R4: A distance presented on dist_i with dist_wr_i high at a clock edge before the trigger rises is the one used by that measurement.
- R5: A distance written while a measurement is running leaves the echo time of that measurement unchanged. It is used by the next measurement.
- R6: Once high, echo_o stays high while trig_i stays high. It goes low on the second rising edge after the first edge that samples trig_i low.
- R7: A low-then-high pulse on trig_i while the delay is still running does not restart or shift the measurement.
- R8: If trig_i has been low for long enough to show low at the synchroniser output when the delay expires, no echo is produced. The block returns to idle, and the next rising edge starts a normal measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| trig_i | input | 1 | Trigger from the controller under test, asynchronous |
| dist_wr_i | input | 1 | Distance write strobe from the simulation host |
| dist_i | input | DIST_W | Simulated distance in units |
| echo_o | output | 1 | Emulated echo-received output |

## Verification
The hardest conditions to reach are the ones inside the delay window: a host write that arrives mid-measurement, and a trigger that dips and recovers before the count expires. The only sign of either is that the echo edge does not move. The stimulus arms a measurement with a known distance, then injects the write or the trigger dip a fixed number of cycles later. The echo rise is then timed against the delay computed from the earlier distance. A cycle-by-cycle behavioural model runs alongside and compares echo_o on every clock, so any drift in count, floor or synchroniser latency is caught.

// File: rtl/ue_pkg.sv
package ue_pkg;

  typedef enum logic [1:0] {
    UE_IDLE = 2'd0,
    UE_WAIT = 2'd1,
    UE_ECHO = 2'd2
  } ue_state_e;

  // Length of the transmit burst in clock cycles, rounded up.
  function automatic int unsigned burst_cycles(longint unsigned clk_hz,
                                               longint unsigned pulses,
                                               longint unsigned tone_hz);
    longint unsigned tmp;
    tmp = (clk_hz * pulses + tone_hz - 1) / tone_hz;
    return int'(tmp);
  endfunction

  // Bits needed to hold the value v.
  function automatic int unsigned bits_for(longint unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/ue_sync.sv
module ue_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic lvl_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;
  logic              prev_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = async_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_comb prev_d = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/ue_dist_reg.sv
module ue_dist_reg #(
  parameter int unsigned DIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DIST_W-1:0] dist_i,
  output logic [DIST_W-1:0] dist_o
);

  logic [DIST_W-1:0] dist_q;
  logic [DIST_W-1:0] dist_d;

  always_comb begin
    dist_d = dist_q;
    if (wr_i) dist_d = dist_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dist_q <= '0;
    else        dist_q <= dist_d;
  end

  assign dist_o = dist_q;

endmodule

// File: rtl/ue_delay_calc.sv
module ue_delay_calc #(
  parameter int unsigned DIST_W       = 12,
  parameter int unsigned DLY_W        = 24,
  parameter int unsigned CYC_PER_UNIT = 5830,
  parameter int unsigned MIN_DLY_CYC  = 32389
) (
  input  logic [DIST_W-1:0] dist_i,
  output logic [DLY_W-1:0]  delay_o
);

  localparam logic [DLY_W-1:0] SCALE = DLY_W'(CYC_PER_UNIT);
  localparam logic [DLY_W-1:0] FLOOR = DLY_W'(MIN_DLY_CYC);

  logic [DLY_W-1:0] prod;

  always_comb begin
    prod    = DLY_W'(dist_i) * SCALE;
    delay_o = (prod < FLOOR) ? FLOOR : prod;
  end

endmodule

// File: rtl/ue_echo_fsm.sv
module ue_echo_fsm
  import ue_pkg::*;
#(
  parameter int unsigned DLY_W       = 24,
  parameter int unsigned MIN_DLY_CYC = 32389
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             lvl_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             echo_o
);

  ue_state_e        state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      UE_IDLE: begin
        if (rise_i) begin
          state_d = UE_WAIT;
          cnt_d   = delay_i - 1'b1;
          cnt_en  = 1'b1;
        end
      end
      UE_WAIT: begin
        if (cnt_q == '0) begin
          state_d = lvl_i ? UE_ECHO : UE_IDLE;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      UE_ECHO: begin
        if (!lvl_i) state_d = UE_IDLE;
      end
      default: state_d = UE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UE_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign echo_o = (state_q == UE_ECHO);

  // R2: the echo only appears when a running count has expired
  a_r2_echo_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(echo_o) |-> ($past(state_q) == UE_WAIT && $past(cnt_q) == '0));

  // R3: a freshly loaded count never undercuts the burst floor
  a_r3_floor_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == UE_IDLE && rise_i) |=> (cnt_q >= DLY_W'(MIN_DLY_CYC - 1)));

  // R6: echo holds while the synchronised trigger stays high
  a_r6_echo_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == UE_ECHO && lvl_i) |=> (state_q == UE_ECHO));

  // R5, R7: a running count only ticks down, whatever the inputs do
  a_r7_count_undisturbed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == UE_WAIT && cnt_q != '0) |=>
      (state_q == UE_WAIT && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/usonic_echo_emu.sv
module usonic_echo_emu
  import ue_pkg::*;
#(
  parameter int unsigned DIST_W       = 12,
  parameter int unsigned CYC_PER_UNIT = 5830,
  parameter int unsigned MIN_DLY_CYC  = ue_pkg::burst_cycles(64'd100_000_000, 64'd16, 64'd49_400),
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              dist_wr_i,
  input  logic [DIST_W-1:0] dist_i,
  output logic              echo_o
);

  localparam longint unsigned PROD_MAX =
    ((64'd1 << DIST_W) - 64'd1) * longint'(CYC_PER_UNIT);
  localparam longint unsigned DLY_MAX =
    (PROD_MAX > longint'(MIN_DLY_CYC)) ? PROD_MAX : longint'(MIN_DLY_CYC);
  localparam int unsigned DLY_W = ue_pkg::bits_for(DLY_MAX);

  logic              trig_lvl;
  logic              trig_rise;
  logic [DIST_W-1:0] dist_cur;
  logic [DLY_W-1:0]  delay;

  ue_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (trig_i),
    .lvl_o   (trig_lvl),
    .rise_o  (trig_rise)
  );

  ue_dist_reg #(.DIST_W(DIST_W)) u_dist (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (dist_wr_i),
    .dist_i (dist_i),
    .dist_o (dist_cur)
  );

  ue_delay_calc #(
    .DIST_W       (DIST_W),
    .DLY_W        (DLY_W),
    .CYC_PER_UNIT (CYC_PER_UNIT),
    .MIN_DLY_CYC  (MIN_DLY_CYC)
  ) u_calc (
    .dist_i  (dist_cur),
    .delay_o (delay)
  );

  ue_echo_fsm #(
    .DLY_W       (DLY_W),
    .MIN_DLY_CYC (MIN_DLY_CYC)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (trig_rise),
    .lvl_i   (trig_lvl),
    .delay_i (delay),
    .echo_o  (echo_o)
  );

  // R1: reset forces the echo low
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !echo_o);

  // R8: echo never rises while the trigger has been low across the sync chain
  a_r8_no_echo_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_lvl && !echo_o) |=> !echo_o);

endmodule

// File: tb/tb_usonic_echo_emu.sv
module tb_usonic_echo_emu;

  localparam int DW  = 8;
  localparam int CPU = 3;
  localparam int MIN = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_i = 1'b0;
  logic          dist_wr_i = 1'b0;
  logic [DW-1:0] dist_i = '0;
  logic          echo_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  usonic_echo_emu #(
    .DIST_W(DW), .CYC_PER_UNIT(CPU), .MIN_DLY_CYC(MIN), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
    .dist_wr_i(dist_wr_i), .dist_i(dist_i), .echo_o(echo_o)
  );

  function automatic int exp_delay(int d);
    int p;
    p = d * CPU;
    return (p < MIN) ? MIN : p;
  endfunction

  // behavioural reference model
  bit hist[$];
  int m_mode = 0;
  int m_rem  = 0;
  int m_dist = 0;
  bit m_echo = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < 4; i++) hist.push_back(1'b0);
      m_mode = 0; m_rem = 0; m_dist = 0; m_echo = 1'b0;
    end else begin
      bit lvl, rise;
      hist.push_front(trig_i);
      while (hist.size() > 4) void'(hist.pop_back());
      lvl  = hist[2];
      rise = hist[2] && !hist[3];
      case (m_mode)
        0: if (rise) begin m_rem = exp_delay(m_dist) - 1; m_mode = 1; end
        1: if (m_rem == 0) m_mode = lvl ? 2 : 0; else m_rem--;
        default: if (!lvl) m_mode = 0;
      endcase
      if (dist_wr_i) m_dist = int'(dist_i);
      m_echo = (m_mode == 2);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (echo_o !== m_echo) begin
        fails++;
        $display("FAIL R2/R6 model compare at %0t: echo_o=%0b expected %0b", $time, echo_o, m_echo);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_dist(int d);
    @(negedge clk); dist_i = DW'(d); dist_wr_i = 1'b1;
    @(negedge clk); dist_wr_i = 1'b0;
  endtask

  // raise trigger at a negedge, return edge count until echo seen high
  task automatic raise_and_time(output int n);
    trig_i = 1'b1;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!echo_o && n < 3000);
  endtask

  task automatic release_and_time(output int n);
    trig_i = 1'b0;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (echo_o && n < 100);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 echo low in reset", int'(echo_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 echo low after reset", int'(echo_o), 0);

    // R3: short distance takes the floor
    write_dist(5);
    raise_and_time(n);
    check("R3 floor delay dist=5", n, exp_delay(5) + 3);
    release_and_time(n);
    check("R6 echo falls after trigger low", n, 3);

    // R2: proportional delay
    write_dist(10);
    raise_and_time(n);
    check("R2 delay dist=10", n, exp_delay(10) + 3);
    repeat (30) @(negedge clk);
    check("R6 echo held while trigger high", int'(echo_o), 1);
    release_and_time(n);

    write_dist(0);
    raise_and_time(n);
    check("R3 floor delay dist=0", n, MIN + 3);
    release_and_time(n);

    write_dist(200);
    raise_and_time(n);
    check("R2 delay dist=200", n, exp_delay(200) + 3);
    release_and_time(n);

    // R4 / R5: write during measurement
    write_dist(10);
    trig_i = 1'b1;
    repeat (5) @(negedge clk);
    dist_i = DW'(100); dist_wr_i = 1'b1;
    @(negedge clk); dist_wr_i = 1'b0;
    n = 6;
    while (!echo_o && n < 3000) begin @(posedge clk); n++; @(negedge clk); end
    check("R5 mid-run write ignored", n, exp_delay(10) + 3);
    release_and_time(n);
    raise_and_time(n);
    check("R4 R5 later measurement uses new distance", n, exp_delay(100) + 3);
    release_and_time(n);

    // R7: trigger dip during delay
    write_dist(10);
    trig_i = 1'b1;
    repeat (8) @(negedge clk);
    trig_i = 1'b0;
    repeat (3) @(negedge clk);
    trig_i = 1'b1;
    n = 11;
    while (!echo_o && n < 3000) begin @(posedge clk); n++; @(negedge clk); end
    check("R7 re-rise during delay ignored", n, exp_delay(10) + 3);
    release_and_time(n);

    // R8: trigger dropped before expiry
    write_dist(10);
    trig_i = 1'b1;
    repeat (10) @(negedge clk);
    trig_i = 1'b0;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (echo_o) n++;
    end
    check("R8 no echo after early release", n, 0);
    write_dist(7);
    raise_and_time(n);
    check("R8 ready for next measurement", n, exp_delay(7) + 3);
    release_and_time(n);
    check("R1 R6 idle at end", int'(echo_o), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule